// File: doc/BRIEF.md
# Serial DAC Write Controller

This block sits on the host side of a three-wire, write-only serial link to a current-output multiplying converter. A requester offers a 14-bit code on a valid/ready handshake. The controller then frames one write. It pulls the active-low select line down and shifts the code out most significant bit first on a data line. The data is clocked by a serial clock built from the system clock. The controller finishes by raising the select line, and that rising edge is what makes the converter take the new code.

The serial clock idles low and the select line idles high. The low phase and high phase of the serial clock are each set in whole system cycles. So are the select hold after the last clock and the gap between frames. These settings let the minimum pulse-width, setup and hold times be met at any system clock rate. Data changes only when the serial clock falls, and it holds steady while the clock is high.

A per-request flag picks between a 14-bit frame and a 16-bit frame. The 16-bit frame begins with two zero bits, which the receiver drops. The controller keeps a shadow copy of the last committed code, which is zero after reset, as the converter's is. It also raises a one-cycle pulse when a write is committed.

Top module: `sdac_link_tx`

## Requirements
- R1: After reset, the select line is high, the serial clock is low, ready is high, the shadow code is 0 and the done pulse is low.
- R2: In narrow mode (width flag 0) a frame carries exactly 14 rising serial clock edges. The bits sampled on those edges are the requested code, bit 13 first and bit 0 last.
- R3: In wide mode (width flag 1) a frame carries exactly 16 rising edges. The first two bits sampled are 0, and the last 14 are the requested code, bit 13 first.
- R4: The serial clock rises only while the select line is low. It stays high for at least HI_CYC system cycles and low for at least LO_CYC system cycles before each rising edge, counting the low time from the select fall for the first edge.
- R5: The data line never changes while the serial clock is high. It is stable for at least LO_CYC system cycles before each rising edge.
- R6: The select line rises no sooner than HI_CYC+TAIL_CYC system cycles after the last rising serial clock edge of the frame.
- R7: Ready is low from the cycle after acceptance for as long as the select line is low. It returns high exactly GAP_CYC cycles after the select rise. The select line therefore stays high for at least GAP_CYC+1 cycles between frames.
- R8: The shadow code takes the committed code in the same cycle that the select line rises. Done is high for exactly that one cycle, and the shadow code changes at no other time.
- R9: A request raised while the controller is busy is held off, not dropped. It is accepted once ready returns, and its code is the one delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_code | input | CODE_W | Code to write |
| req_wide | input | 1 | 1 selects the 16-bit frame with two leading zeros |
| req_ready | output | 1 | Controller can take a request |
| link_csn | output | 1 | Active-low select of the serial link |
| link_sclk | output | 1 | Serial clock, idles low |
| link_sdo | output | 1 | Serial data, most significant bit first |
| shadow | output | CODE_W | Last committed code |
| done | output | 1 | One-cycle pulse when a code is committed |

## Verification
The select line falls on the edge that accepts a request. Each serial clock rise follows LO_CYC cycles after the select fall or after the previous clock fall, and each fall follows HI_CYC cycles after the rise. The select rises HI_CYC+TAIL_CYC cycles after the last rise, with done and the new shadow code in that same cycle. Ready returns GAP_CYC cycles later. A receiver model in the bench samples every output on the falling system clock edge and counts run lengths in whole cycles. It compares those counts against these exact cycle offsets, and it checks the delivered code at the moment the select line rises.

// File: rtl/sdac_link_tx.sv
module sdac_link_tx #(
  parameter int CODE_W   = 14,
  parameter int EXT_W    = 16,
  parameter int LO_CYC   = 3,
  parameter int HI_CYC   = 3,
  parameter int TAIL_CYC = 2,
  parameter int GAP_CYC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [CODE_W-1:0] req_code,
  input  logic              req_wide,
  output logic              req_ready,
  output logic              link_csn,
  output logic              link_sclk,
  output logic              link_sdo,
  output logic [CODE_W-1:0] shadow,
  output logic              done
);

  localparam int M1   = (LO_CYC > HI_CYC) ? LO_CYC : HI_CYC;
  localparam int M2   = (TAIL_CYC > GAP_CYC) ? TAIL_CYC : GAP_CYC;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int TW   = $clog2(MAXC + 1);
  localparam int BW   = $clog2(EXT_W + 1);
  localparam int PADW = EXT_W - CODE_W;

  typedef enum logic [2:0] {S_IDLE, S_LOW, S_HIGH, S_TAIL, S_GAP} st_t;

  st_t               st;
  logic [TW-1:0]     tmr;
  logic [BW-1:0]     left;
  logic [EXT_W-1:0]  sh;
  logic [CODE_W-1:0] hold;

  wire tmr_end = (tmr == '0);
  wire take    = req_valid && req_ready;

  assign req_ready = (st == S_IDLE);
  assign link_sdo  = sh[EXT_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      tmr       <= '0;
      left      <= '0;
      sh        <= '0;
      hold      <= '0;
      shadow    <= '0;
      done      <= 1'b0;
      link_csn  <= 1'b1;
      link_sclk <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!tmr_end) tmr <= tmr - 1'b1;
      case (st)
        S_IDLE: if (take) begin
          link_csn <= 1'b0;
          hold     <= req_code;
          sh       <= req_wide ? EXT_W'(req_code) : {req_code, {PADW{1'b0}}};
          left     <= req_wide ? BW'(EXT_W) : BW'(CODE_W);
          tmr      <= TW'(LO_CYC - 1);
          st       <= S_LOW;
        end
        S_LOW: if (tmr_end) begin
          link_sclk <= 1'b1;
          tmr       <= TW'(HI_CYC - 1);
          st        <= S_HIGH;
        end
        S_HIGH: if (tmr_end) begin
          link_sclk <= 1'b0;
          if (left == BW'(1)) begin
            tmr <= TW'(TAIL_CYC - 1);
            st  <= S_TAIL;
          end else begin
            sh   <= sh << 1;
            left <= left - 1'b1;
            tmr  <= TW'(LO_CYC - 1);
            st   <= S_LOW;
          end
        end
        S_TAIL: if (tmr_end) begin
          link_csn <= 1'b1;
          shadow   <= hold;
          done     <= 1'b1;
          sh       <= '0;
          tmr      <= TW'(GAP_CYC - 1);
          st       <= S_GAP;
        end
        S_GAP: if (tmr_end) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r4_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
    link_csn |-> !link_sclk);

  a_r5_sdo_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (link_sclk && $past(link_sclk)) |-> $stable(link_sdo));

  a_r7_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !link_csn |-> !req_ready);

  a_r8_done_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_csn) |-> done);

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(shadow));

endmodule

// File: tb/sim_sdac_link_tx.sv
`timescale 1ns/1ps
module sim_sdac_link_tx;
  localparam int LO = 3, HI = 3, TL = 2, GP = 2;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_wide = 0;
  logic [13:0] req_code = '0;
  logic req_ready, link_csn, link_sclk, link_sdo, done;
  logic [13:0] shadow;

  sdac_link_tx #(.CODE_W(14), .EXT_W(16), .LO_CYC(LO), .HI_CYC(HI),
                 .TAIL_CYC(TL), .GAP_CYC(GP)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_code(req_code),
    .req_wide(req_wide), .req_ready(req_ready), .link_csn(link_csn),
    .link_sclk(link_sclk), .link_sdo(link_sdo), .shadow(shadow), .done(done));

  always #2 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  int n_issued = 0, n_rx = 0, n_held = 0;
  int err_r4 = 0, err_r5 = 0, err_r6 = 0, err_r7 = 0;
  logic [13:0] exp_code [0:1023];
  bit          exp_wide [0:1023];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int bits_of(input bit w);
    return w ? 16 : 14;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(0, "watchdog", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  logic p_sclk = 0, p_csn = 1, p_sdo = 0, p_rdy = 1;
  int run = 100, since = 100, last_rise = 0, last_csn_rise = -1000;
  int rx_n = 0;
  logic [15:0] rx_sh = '0;

  always @(negedge clk) if (rst_n) begin
    if (link_sdo != p_sdo) since = 0; else since++;
    if (link_sdo != p_sdo && link_sclk && p_sclk) err_r5++;
    if (link_sclk && !p_sclk) begin
      if (link_csn || p_csn) err_r4++;
      if (run < LO) err_r4++;
      if (since < LO) err_r5++;
      rx_sh = {rx_sh[14:0], link_sdo};
      rx_n++;
      last_rise = cyc;
    end
    if (!link_sclk && p_sclk && run < HI) err_r4++;
    if (link_sclk != p_sclk) run = 1; else run++;
    if (!link_csn && p_csn) begin
      if (cyc - last_csn_rise < GP + 1) err_r7++;
      rx_n = 0; rx_sh = '0;
    end
    if (!link_csn && req_ready) err_r7++;
    if (req_ready && !p_rdy && cyc - last_csn_rise != GP) err_r7++;
    if (link_csn && !p_csn) begin
      last_csn_rise = cyc;
      if (cyc - last_rise < HI + TL) err_r6++;
      if (req_ready) err_r7++;
      if (exp_wide[n_rx]) begin
        chk(rx_n == 16, "R3 bit count", rx_n, 16);
        chk(rx_sh[15:14] == 2'b00, "R3 leading bits", rx_sh[15:14], 0);
        chk(rx_sh[13:0] == exp_code[n_rx], "R3 code", rx_sh[13:0], exp_code[n_rx]);
      end else begin
        chk(rx_n == 14, "R2 bit count", rx_n, 14);
        chk(rx_sh[13:0] == exp_code[n_rx], "R2 code", rx_sh[13:0], exp_code[n_rx]);
      end
      chk(done && shadow == exp_code[n_rx], "R8 shadow at select rise", shadow, exp_code[n_rx]);
      n_rx++;
    end else if (done) chk(0, "R8 stray done", 1, 0);
    p_sclk = link_sclk; p_csn = link_csn; p_sdo = link_sdo; p_rdy = req_ready;
  end

  task automatic issue(input logic [13:0] c, input bit w);
    @(negedge clk);
    exp_code[n_issued] = c;
    exp_wide[n_issued] = w;
    req_code = c; req_wide = w; req_valid = 1;
    if (!req_ready) n_held++;
    while (!req_ready) begin
      @(negedge clk);
      req_code = c;
    end
    @(negedge clk);
    req_valid = 0; req_code = ~c;
    n_issued++;
  endtask

  task automatic drain;
    while (n_rx != n_issued) @(negedge clk);
    repeat (GP + 2) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(link_csn == 1 && link_sclk == 0, "R1 idle lines", {link_csn, link_sclk}, 2);
    chk(req_ready == 1 && done == 0, "R1 handshake", {req_ready, done}, 2);
    chk(shadow == 0, "R1 shadow", shadow, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(link_csn == 1 && req_ready == 1 && shadow == 0, "R1 after release", shadow, 0);

    issue(14'h3FFF, 0); drain();
    issue(14'h0000, 0); drain();
    issue(14'h2000, 1); drain();
    issue(14'h0001, 1); drain();
    issue(14'h1555, 0); issue(14'h2AAA, 1); issue(14'h3001, 0); drain();
    chk(shadow == 14'h3001, "R9 held request committed", shadow, 14'h3001);

    for (int i = 0; i < 150; i++) begin
      issue(14'($urandom), 1'($urandom));
      repeat ($urandom_range(0, 4)) @(negedge clk);
    end
    drain();

    chk(n_rx == n_issued, "R9 no request dropped", n_rx, n_issued);
    chk(n_held > 0, "R9 held requests seen", n_held, 1);
    chk(err_r4 == 0, "R4 clock widths", err_r4, 0);
    chk(err_r5 == 0, "R5 data stability", err_r5, 0);
    chk(err_r6 == 0, "R6 select hold", err_r6, 0);
    chk(err_r7 == 0, "R7 ready and gap", err_r7, 0);
    chk(done == 0 && link_csn == 1 && link_sclk == 0, "R8 idle after last frame", done, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule